// File: doc/BRIEF.md
# Burst Transfer Address Sequencer

This block takes charge of the internal register address and the read/write selection while the register bus performs a burst transfer. Its main use is to stream words into or out of per-channel waveform memory without sending a separate address cycle for each word. The registered bus inputs reach it every clock cycle. When an address cycle carries the reserved burst-start code in its upper address bits, the sequencer latches the start address and the direction. It then presents a new internal address each cycle for as long as the address strobe stays high. The cycle in which the strobe falls is the last cycle of the burst.

Write bursts produce one write strobe per cycle and advance the address by one each time. Read bursts issue their addresses in the same way, and a fixed-latency pipeline derives the read-data drive enable from them. In extended-hold mode a read address is held for two cycles, so each read word stays on the bus for two cycles. After a read burst the sequencer reports busy long enough for the drivers to release the bus and for two idle cycles to pass. Any start request that arrives while it is busy is dropped.

Top module: `burst_seq`

## Requirements
- R1: A burst starts only when the sequencer is idle and a cycle has `strobe_i` high with the top CODE_W bits of `addr_i` equal to BURST_CODE (default 4'hF). The low ADDR_W-CODE_W bits give the start address. An address cycle that carries any other code leaves the sequencer idle.
- R2: After the start cycle, `seq_own_o` is high for every cycle up to and including the first cycle in which `strobe_i` is low. It is low in the cycle after that.
- R3: The direction is taken from `read_i` (1 = read) in the start cycle. `seq_rd_o` keeps that value for the whole burst, whatever `read_i` does.
- R4: In a write burst, `wr_stb_o` is high in every owned cycle and `rd_drv_o` stays low. The k-th owned cycle (k from 0) presents address start+k.
- R5: In a read burst, `rd_drv_o` is high exactly RD_LAT cycles after each owned cycle. With the defaults, the first word is driven 4 cycles after the start cycle.
- R6: When `xhold_i` is high in the start cycle of a read burst, the k-th owned cycle presents start+floor(k/2). `xhold_i` has no effect on write bursts.
- R7: After the last owned cycle of a read burst, `busy_o` stays high for RD_LAT+GAP_CYC cycles (default 3+2). This covers the final drive cycle and then two undriven cycles. Start requests made during this time are ignored.
- R8: The internal address wraps from all ones to zero within ADDR_W-CODE_W bits (default 12). It never carries into the code or select field.
- R9: During reset and right after it, `busy_o`, `seq_own_o`, `seq_rd_o`, `wr_stb_o` and `rd_drv_o` are low.
- R10: After a write burst, the sequencer is idle in the cycle that follows the last owned cycle. A new start in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Registered address strobe |
| read_i | input | 1 | Registered direction, 1 = read |
| xhold_i | input | 1 | Extended read-data hold select, sampled at start |
| addr_i | input | ADDR_W | Registered address field; top CODE_W bits hold the code |
| busy_o | output | 1 | Burst or post-read guard in progress |
| seq_own_o | output | 1 | Sequencer drives the internal address this cycle |
| seq_rd_o | output | 1 | Latched burst direction while owning |
| seq_addr_o | output | ADDR_W-CODE_W | Internal register address |
| wr_stb_o | output | 1 | Write word accepted this cycle |
| rd_drv_o | output | 1 | Read data drive enable for the bus |

## Verification
The bench flips `read_i` and `xhold_i` on every cycle of a burst. A design that samples the direction again mid-burst would then toggle the strobe types, and one that samples the hold mode again would change the address pacing. Bursts that start at 12'hFFE and 12'hFFF check the address wrap. A wrong wrap would show addresses that carry into the code bits or that stop at all ones. A one-cycle burst checks that the sequencer ends in the same cycle the strobe drops rather than one cycle later. A start request placed in the last guard cycle after a read checks the turnaround gap, because a design with a gap that is too short would begin a new burst there.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
   typedef enum logic [1:0] {
      BS_IDLE  = 2'd0,
      BS_WRITE = 2'd1,
      BS_READ  = 2'd2,
      BS_DRAIN = 2'd3
   } bs_state_e;
endpackage

// File: rtl/bseq_start_detect.sv
module bseq_start_detect #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CODE_W = 4,
   parameter int unsigned CODE   = 15,
   localparam int unsigned REG_W = ADDR_W - CODE_W
) (
   input  logic              idle_i,
   input  logic              strobe_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              start_o,
   output logic [REG_W-1:0]  base_o
);
   logic code_hit;

   assign code_hit = (addr_i[ADDR_W-1 -: CODE_W] == CODE_W'(CODE));
   assign start_o  = idle_i & strobe_i & code_hit;
   assign base_o   = addr_i[REG_W-1:0];
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen #(
   parameter int unsigned REG_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [REG_W-1:0] base_i,
   input  logic             step_i,
   input  logic             pair_i,
   output logic [REG_W-1:0] addr_o
);
   logic [REG_W-1:0] addr_q;
   logic             phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         phase_q <= 1'b0;
      end else if (load_i) begin
         addr_q  <= base_i;
         phase_q <= 1'b0;
      end else if (step_i) begin
         if (!pair_i || phase_q) addr_q <= addr_q + 1'b1;
         phase_q <= pair_i & ~phase_q;
      end
   end

   assign addr_o = addr_q;

   AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && pair_i && !phase_q) |=> $stable(addr_o)); // R6
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !pair_i) |=> (addr_o == REG_W'($past(addr_o) + 1'b1))); // R4
   AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !pair_i && (addr_o == '1)) |=> (addr_o == '0)); // R8
endmodule

// File: rtl/bseq_drive_pipe.sv
module bseq_drive_pipe #(
   parameter int unsigned LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue_i,
   output logic drive_o
);
   logic pend;

   generate
      if (LAT == 1) begin : g_single
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= issue_i;
         end
         assign drive_o = q;
         assign pend    = q;
      end else begin : g_shift
         logic [LAT-1:0] sh;
         always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[LAT-2:0], issue_i};
         end
         assign drive_o = sh[LAT-1];
         assign pend    = |sh[LAT-2:0];
      end
   endgenerate

   AST_NO_STRAY_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue_i && !pend) |=> !drive_o); // R5
endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import bseq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned CODE_W     = 4,
   parameter int unsigned BURST_CODE = 15,
   parameter int unsigned RD_LAT     = 3,
   parameter int unsigned GAP_CYC    = 2,
   localparam int unsigned REG_W     = ADDR_W - CODE_W,
   localparam int unsigned CNT_W     = $clog2(RD_LAT + GAP_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_i,
   input  logic              read_i,
   input  logic              xhold_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              busy_o,
   output logic              seq_own_o,
   output logic              seq_rd_o,
   output logic [REG_W-1:0]  seq_addr_o,
   output logic              wr_stb_o,
   output logic              rd_drv_o
);
   generate
      if (CODE_W < 1 || CODE_W >= ADDR_W) begin : g_bad_code
         $error("burst_seq: CODE_W must be between 1 and ADDR_W-1");
      end
      if (BURST_CODE >= (1 << CODE_W)) begin : g_bad_value
         $error("burst_seq: BURST_CODE does not fit in CODE_W bits");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("burst_seq: RD_LAT must be at least 1");
      end
      if (GAP_CYC < 2) begin : g_bad_gap
         $error("burst_seq: GAP_CYC must be at least 2");
      end
   endgenerate

   bs_state_e        state_q, state_d;
   logic             dir_q, pair_q;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             start;
   logic [REG_W-1:0] base;
   logic             idle, owning;

   assign idle   = (state_q == BS_IDLE);
   assign owning = (state_q == BS_WRITE) || (state_q == BS_READ);

   bseq_start_detect #(
      .ADDR_W (ADDR_W),
      .CODE_W (CODE_W),
      .CODE   (BURST_CODE)
   ) u_detect (
      .idle_i   (idle),
      .strobe_i (strobe_i),
      .addr_i   (addr_i),
      .start_o  (start),
      .base_o   (base)
   );

   bseq_addr_gen #(
      .REG_W (REG_W)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start),
      .base_i (base),
      .step_i (owning),
      .pair_i (pair_q),
      .addr_o (seq_addr_o)
   );

   bseq_drive_pipe #(
      .LAT (RD_LAT)
   ) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue_i (state_q == BS_READ),
      .drive_o (rd_drv_o)
   );

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         BS_IDLE: begin
            if (start) state_d = read_i ? BS_READ : BS_WRITE;
         end
         BS_WRITE: begin
            if (!strobe_i) state_d = BS_IDLE;
         end
         BS_READ: begin
            if (!strobe_i) begin
               state_d = BS_DRAIN;
               cnt_d   = CNT_W'(RD_LAT + GAP_CYC - 1);
            end
         end
         BS_DRAIN: begin
            if (cnt_q == '0) state_d = BS_IDLE;
            else             cnt_d   = cnt_q - 1'b1;
         end
         default: state_d = BS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= BS_IDLE;
         cnt_q   <= '0;
         dir_q   <= 1'b0;
         pair_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         if (start) begin
            dir_q  <= read_i;
            pair_q <= read_i & xhold_i;
         end
      end
   end

   assign busy_o    = !idle;
   assign seq_own_o = owning;
   assign seq_rd_o  = owning & dir_q;
   assign wr_stb_o  = (state_q == BS_WRITE);

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> seq_own_o); // R1
   AST_LAST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_own_o && !strobe_i) |=> !seq_own_o); // R2
   AST_DIR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      seq_own_o |=> (!seq_own_o || $stable(seq_rd_o))); // R3
   AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |-> !rd_drv_o); // R4
   AST_GAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_drv_o) |-> busy_o); // R7
   AST_GAP_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_drv_o) |=> busy_o); // R7
   AST_DRAIN_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !seq_own_o) |=> !seq_own_o); // R7
endmodule

// File: tb/burst_seq_test.sv
module burst_seq_test;
   localparam int ADDR_W = 16;
   localparam int CODE_W = 4;
   localparam int LAT    = 3;
   localparam int GAP    = 2;
   localparam int REG_W  = ADDR_W - CODE_W;

   // {read, xhold, base[11:0], len[7:0], poke}
   localparam int NV = 7;
   localparam logic [22:0] VEC [NV] = '{
      {1'b0, 1'b0, 12'h010, 8'd4, 1'b0},
      {1'b0, 1'b1, 12'h200, 8'd3, 1'b0},
      {1'b1, 1'b0, 12'h040, 8'd5, 1'b1},
      {1'b1, 1'b1, 12'h300, 8'd6, 1'b0},
      {1'b0, 1'b0, 12'hFFE, 8'd4, 1'b0},
      {1'b1, 1'b1, 12'hFFF, 8'd5, 1'b1},
      {1'b1, 1'b0, 12'h007, 8'd1, 1'b0}
   };

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n, strobe, read, xhold;
   logic [ADDR_W-1:0] addr;
   logic              busy, own, seq_rd, wr_stb, rd_drv;
   logic [REG_W-1:0]  seq_addr;

   int checks = 0;
   int errors = 0;

   burst_seq uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe_i   (strobe),
      .read_i     (read),
      .xhold_i    (xhold),
      .addr_i     (addr),
      .busy_o     (busy),
      .seq_own_o  (own),
      .seq_rd_o   (seq_rd),
      .seq_addr_o (seq_addr),
      .wr_stb_o   (wr_stb),
      .rd_drv_o   (rd_drv)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic run_burst(input logic rd, input logic xh, input logic [11:0] base,
                            input int len, input logic poke);
      logic [11:0] ea;
      string       atag;
      @(negedge clk);
      strobe = 1'b1; read = rd; xhold = xh; addr = {4'hF, base};
      tick();
      for (int j = 0; j <= len + LAT + GAP; j++) begin
         strobe = (j < len - 1) || (poke && (j == len + LAT + 1));
         read   = ~read;
         xhold  = ~xhold;
         addr   = poke ? {4'hF, 12'h123} : {4'h0, 12'hABC};
         chk("R2", "own", own, j < len);
         chk(rd ? "R7" : "R10", "busy", busy, rd ? (j < len + LAT + GAP) : (j < len));
         chk("R5", "drive", rd_drv, rd && (j >= LAT) && (j < len + LAT));
         chk("R4", "wr_stb", wr_stb, !rd && (j < len));
         chk("R3", "dir", seq_rd, rd && (j < len));
         if (j < len) begin
            ea   = base + 12'((rd && xh) ? j / 2 : j);
            atag = (ea < base) ? "R8" : ((rd && xh) ? "R6" : "R4");
            chk(atag, "addr", seq_addr, ea);
         end
         tick();
      end
      strobe = 1'b0; read = 1'b0; xhold = 1'b0; addr = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; strobe = 1'b1; read = 1'b1; xhold = 1'b0; addr = {4'hF, 12'h055};
      repeat (3) tick();
      // R9: reset state
      chk("R9", "busy", busy, 0);
      chk("R9", "own", own, 0);
      chk("R9", "dir", seq_rd, 0);
      chk("R9", "wr_stb", wr_stb, 0);
      chk("R9", "drive", rd_drv, 0);
      @(negedge clk);
      rst_n = 1'b1; strobe = 1'b0; read = 1'b0; addr = '0;
      tick();
      chk("R9", "busy after release", busy, 0);

      for (int v = 0; v < NV; v++) begin
         run_burst(VEC[v][22], VEC[v][21], VEC[v][20:9], int'(VEC[v][8:1]), VEC[v][0]);
      end

      // R1: strobe with a non-burst code stays idle
      @(negedge clk);
      strobe = 1'b1; read = 1'b0; addr = {4'h3, 12'h055};
      tick();
      strobe = 1'b0; addr = '0;
      chk("R1", "own on other code", own, 0);
      chk("R1", "busy on other code", busy, 0);

      // R10: start accepted in the cycle after a write burst ends
      @(negedge clk);
      strobe = 1'b1; read = 1'b0; addr = {4'hF, 12'h080};
      tick();
      strobe = 1'b0;
      chk("R1", "own after start", own, 1);
      chk("R1", "start address", seq_addr, 12'h080);
      tick();
      chk("R10", "idle after write", busy, 0);
      strobe = 1'b1; addr = {4'hF, 12'h0A0};
      tick();
      strobe = 1'b0; addr = '0;
      chk("R10", "own on restart", own, 1);
      chk("R10", "restart address", seq_addr, 12'h0A0);
      chk("R10", "restart write", wr_stb, 1);
      tick();
      chk("R2", "own after single", own, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule